// File: doc/BRIEF.md
# Dual-Half Up-Counting Timer

A memory-mapped timer built around one 64-bit up-counter that software can run either as two fully independent 32-bit halves or as a single 64-bit counter. Each half owns a counter register, a period register, a two-bit enable-mode field and a reset-release bit, and drives its own interrupt line. A running half counts one step per clock. When its count reaches its period it raises a single-cycle interrupt pulse and restarts from zero. In one-shot mode it also clears its own enable mode, so it stops after the first period.

Software reaches the block over a simple word-addressed bus. A write is taken on the clock edge at which `bus_we` is high. Reads are combinational from `bus_addr`. Global control picks the timer mode and releases each half from reset. The two halves' enable-mode fields share one control word. The chained and watchdog timer modes are not implemented: selecting either one freezes both counters.

Top module: `dual_half_timer`

## Requirements
- R1: After reset every register reads zero except the identity word at word 0 (byte 0x00), which returns the `ID_VALUE` parameter, and both interrupt outputs are low.
- R2: Register words are: identity 0, low counter 4 (0x10), high counter 5 (0x14), low period 6 (0x18), high period 7 (0x1C), control 8 (0x20), global control 9 (0x24). Control holds the low enable mode in bits 7:6 and the high enable mode in bits 23:22. Global control holds the low release in bit 0, the high release in bit 1 and the timer mode in bits 3:2. Every other bit reads zero.
- R3: With timer mode 1 (split), a released half whose enable mode is 1 (one-shot) or 2 (periodic) adds one to its counter each clock. Enable mode 0 or 3 holds the counter.
- R4: On the clock edge at which a running half's counter equals its period, that half's counter goes to zero and its interrupt is high for exactly the following cycle.
- R5: In periodic mode a half keeps running after a match, so a period value P gives one interrupt every P+1 clocks.
- R6: In one-shot mode the half's enable-mode field reads 0 after the first match, and the counter then stays at zero with no further interrupts.
- R7: While a half's release bit is 0, its counter is zero, writes to its counter are discarded, its enable mode is ignored and its interrupt stays low.
- R8: A bus write to a counter register of a released half loads the written value, and the value is held while that half is disabled.
- R9: With timer mode 0 (64-bit), the two counters form one 64-bit count that carries from low to high. The count runs only when both release bits are 1, and it is governed by the low enable mode. The match compares the full 64-bit period and pulses the low interrupt. The high enable mode is ignored and the high interrupt stays low.
- R10: With timer mode 2 or 3, neither counter advances and no interrupts occur. Counter writes still take effect.
- R11: In split mode the halves are independent: one half running does not change the other half's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters step once per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lo | output | 1 | Low-half (or 64-bit) period-match pulse |
| irq_hi | output | 1 | High-half period-match pulse |

## Verification
The bench times the interrupt pulses against the count. A design that matched one cycle late, or restarted at one instead of zero, would shift the pulse train away from one pulse every P+1 clocks. A one-shot design that forgot to clear its enable mode would show up as a second pulse and a nonzero mode readback. In 64-bit mode the bench starts the count just below the low-word wrap to check the carry, and to check that the match waits for the high word instead of firing on the low word alone. Other cases load counters while a half is held in reset or frozen by an unsupported timer mode, where a wrong design would keep the written value or keep counting.

// File: rtl/dual_half_timer.sv
module dual_half_timer #(
  parameter logic [31:0] ID_VALUE = 32'h0001_0A51,
  parameter int          AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam logic [AW-1:0] A_ID    = AW'(0);
  localparam logic [AW-1:0] A_CNTLO = AW'(4);
  localparam logic [AW-1:0] A_CNTHI = AW'(5);
  localparam logic [AW-1:0] A_PRDLO = AW'(6);
  localparam logic [AW-1:0] A_PRDHI = AW'(7);
  localparam logic [AW-1:0] A_CTRL  = AW'(8);
  localparam logic [AW-1:0] A_GCTRL = AW'(9);
  localparam logic [1:0] EN_ONCE = 2'd1;
  localparam logic [1:0] EN_LOOP = 2'd2;
  localparam logic [1:0] TM_WIDE  = 2'd0;
  localparam logic [1:0] TM_SPLIT = 2'd1;

  logic [31:0] cnt_lo, cnt_hi, prd_lo, prd_hi;
  logic [1:0]  en_lo, en_hi, tmode;
  logic        rel_lo, rel_hi;

  wire wr_cnt_lo = bus_we && bus_addr == A_CNTLO;
  wire wr_cnt_hi = bus_we && bus_addr == A_CNTHI;
  wire wr_ctrl   = bus_we && bus_addr == A_CTRL;

  wire act_lo = en_lo == EN_ONCE || en_lo == EN_LOOP;
  wire act_hi = en_hi == EN_ONCE || en_hi == EN_LOOP;

  wire run_lo_s = tmode == TM_SPLIT && rel_lo && act_lo;
  wire run_hi_s = tmode == TM_SPLIT && rel_hi && act_hi;
  wire run_wide = tmode == TM_WIDE && rel_lo && rel_hi && act_lo;

  wire hit_lo_s = run_lo_s && cnt_lo == prd_lo;
  wire hit_hi_s = run_hi_s && cnt_hi == prd_hi;
  wire hit_wide = run_wide && {cnt_hi, cnt_lo} == {prd_hi, prd_lo};
  wire hit_lo   = hit_lo_s || hit_wide;

  always_ff @(posedge clk) begin
    if (!rst_n || !rel_lo)         cnt_lo <= '0;
    else if (wr_cnt_lo)            cnt_lo <= bus_wdata;
    else if (hit_lo)               cnt_lo <= '0;
    else if (run_lo_s || run_wide) cnt_lo <= cnt_lo + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rel_hi)   cnt_hi <= '0;
    else if (wr_cnt_hi)      cnt_hi <= bus_wdata;
    else if (hit_hi_s || hit_wide) cnt_hi <= '0;
    else if (run_hi_s || (run_wide && cnt_lo == 32'hFFFF_FFFF))
      cnt_hi <= cnt_hi + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_lo <= '0;
      prd_hi <= '0;
      tmode  <= '0;
      rel_lo <= 1'b0;
      rel_hi <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == A_PRDLO) prd_lo <= bus_wdata;
      if (bus_addr == A_PRDHI) prd_hi <= bus_wdata;
      if (bus_addr == A_GCTRL) begin
        rel_lo <= bus_wdata[0];
        rel_hi <= bus_wdata[1];
        tmode  <= bus_wdata[3:2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_lo <= '0;
      en_hi <= '0;
    end else if (wr_ctrl) begin
      en_lo <= bus_wdata[7:6];
      en_hi <= bus_wdata[23:22];
    end else begin
      if (hit_lo && en_lo == EN_ONCE)   en_lo <= '0;
      if (hit_hi_s && en_hi == EN_ONCE) en_hi <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= hit_lo;
      irq_hi <= hit_hi_s;
    end
  end

  always_comb begin
    case (bus_addr)
      A_ID:    bus_rdata = ID_VALUE;
      A_CNTLO: bus_rdata = cnt_lo;
      A_CNTHI: bus_rdata = cnt_hi;
      A_PRDLO: bus_rdata = prd_lo;
      A_PRDHI: bus_rdata = prd_hi;
      A_CTRL:  bus_rdata = {8'd0, en_hi, 14'd0, en_lo, 6'd0};
      A_GCTRL: bus_rdata = {28'd0, tmode, rel_hi, rel_lo};
      default: bus_rdata = '0;
    endcase
  end

  assert_lo_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_lo |=> (cnt_lo == 32'd0 && !irq_lo));
  assert_hi_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_hi |=> (cnt_hi == 32'd0 && !irq_hi));
  assert_lo_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lo_s && !hit_lo_s && !wr_cnt_lo) |=> cnt_lo == $past(cnt_lo) + 32'd1);
  assert_hi_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_hi_s && !hit_hi_s && !wr_cnt_hi) |=> cnt_hi == $past(cnt_hi) + 32'd1);
  assert_match_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo_s && !wr_cnt_lo) |=> (irq_lo && cnt_lo == 32'd0));
  assert_once_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && en_lo == EN_ONCE && !wr_ctrl) |=> en_lo == 2'd0);
  assert_hi_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode != TM_SPLIT) |=> !irq_hi);
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode[1] && rel_lo && !wr_cnt_lo) |=> $stable(cnt_lo));
endmodule

// File: tb/dual_half_timer_tb_top.sv
`timescale 1ns/1ps
module dual_half_timer_tb_top;
  localparam logic [31:0] IDV = 32'h0001_0A51;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dual_half_timer #(.ID_VALUE(IDV), .AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  typedef struct packed {
    logic        we;
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic [3:0]  idle;
    logic [3:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0, 32'h0,          4'd0, 4'd0, IDV,          4'd1},  // R1 identity
    '{1'b0, 4'd0, 32'h0,          4'd0, 4'd9, 32'h0,        4'd1},  // R1 gctrl
    '{1'b0, 4'd0, 32'h0,          4'd0, 4'd4, 32'h0,        4'd1},  // R1 counter
    '{1'b1, 4'd6, 32'h9,          4'd0, 4'd6, 32'h9,        4'd2},  // R2 period
    '{1'b1, 4'd8, 32'hFFFF_FFFF,  4'd0, 4'd8, 32'h00C0_00C0, 4'd2}, // R2 ctrl fields
    '{1'b1, 4'd9, 32'hFFFF_FFFF,  4'd0, 4'd9, 32'hF,        4'd2},  // R2 gctrl fields
    '{1'b1, 4'd8, 32'h0080_0080,  4'd5, 4'd4, 32'h0,        4'd10}, // R10 mode 3
    '{1'b1, 4'd4, 32'h100,        4'd3, 4'd4, 32'h100,      4'd10}, // R10 frozen
    '{1'b1, 4'd9, 32'h4,          4'd1, 4'd4, 32'h0,        4'd7},  // R7 reset clears
    '{1'b1, 4'd4, 32'h55,         4'd0, 4'd4, 32'h0,        4'd7},  // R7 write dropped
    '{1'b1, 4'd8, 32'h0,          4'd0, 4'd8, 32'h0,        4'd2},  // R2 ctrl clear
    '{1'b1, 4'd9, 32'h7,          4'd0, 4'd4, 32'h0,        4'd3},  // R3 disabled hold
    '{1'b1, 4'd5, 32'h20,         4'd4, 4'd5, 32'h20,       4'd8},  // R8 load held
    '{1'b1, 4'd7, 32'h30,         4'd0, 4'd7, 32'h30,       4'd2},  // R2 high period
    '{1'b1, 4'd8, 32'h0080_0000,  4'd5, 4'd5, 32'h25,       4'd3},  // R3 counting
    '{1'b0, 4'd0, 32'h0,          4'd0, 4'd4, 32'h0,        4'd11}, // R11 other half
    '{1'b1, 4'd8, 32'h0,          4'd0, 4'd5, 32'h26,       4'd3}   // R3 last step
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int pulses, first, hi_pulses;
    tick(); tick();
    chk("R1 irq_lo", {31'd0, irq_lo}, 32'd0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].waddr, VECS[i].wdata);
      for (int k = 0; k < int'(VECS[i].idle); k++) tick();
      rd(VECS[i].raddr, v);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
    end

    // R5 / R4: periodic, period 3
    wr(4'd4, 32'h0); wr(4'd6, 32'h3); wr(4'd8, 32'h80);
    pulses = 0; first = -1; hi_pulses = 0;
    for (int i = 1; i <= 16; i++) begin
      tick();
      if (irq_lo) begin
        pulses++;
        if (first < 0) first = i;
        rd(4'd4, v);
        chk("R4 counter zero at pulse", v, 32'h0);
      end
      if (irq_hi) hi_pulses++;
    end
    chk("R5 pulse count", pulses, 4);
    chk("R4 first pulse cycle", first, 4);
    chk("R11 high quiet", hi_pulses, 0);
    wr(4'd8, 32'h0);

    // R6: one-shot, period 2
    wr(4'd4, 32'h0); wr(4'd6, 32'h2); wr(4'd8, 32'h40);
    pulses = 0; first = -1;
    for (int i = 1; i <= 10; i++) begin
      tick();
      if (irq_lo) begin pulses++; if (first < 0) first = i; end
    end
    chk("R6 single pulse", pulses, 1);
    chk("R6 pulse cycle", first, 3);
    rd(4'd8, v); chk("R6 mode cleared", v, 32'h0);
    rd(4'd4, v); chk("R6 counter rests", v, 32'h0);

    // R9: 64-bit mode carry and full match
    wr(4'd9, 32'h3);
    wr(4'd4, 32'hFFFF_FFFE); wr(4'd5, 32'h0);
    wr(4'd6, 32'h1); wr(4'd7, 32'h1);
    wr(4'd8, 32'h0080_0080);
    hi_pulses = 0;
    tick(); tick();
    rd(4'd5, v); chk("R9 carry high", v, 32'h1);
    rd(4'd4, v); chk("R9 carry low", v, 32'h0);
    tick();
    chk("R9 no early match", {31'd0, irq_lo}, 32'd0);
    if (irq_hi) hi_pulses++;
    tick();
    chk("R9 full match pulse", {31'd0, irq_lo}, 32'd1);
    if (irq_hi) hi_pulses++;
    rd(4'd5, v); chk("R9 high restart", v, 32'h0);
    chk("R9 high line quiet", hi_pulses, 0);

    // R1: reset mid-run
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    rd(4'd4, v); chk("R1 counter after reset", v, 32'h0);
    rd(4'd8, v); chk("R1 ctrl after reset", v, 32'h0);
    rd(4'd9, v); chk("R1 gctrl after reset", v, 32'h0);
    rd(4'd0, v); chk("R1 identity after reset", v, IDV);
    chk("R1 irqs after reset", {30'd0, irq_hi, irq_lo}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule